// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is a slave on a two-wire serial bus (the common I2C-style clock and data pair). It gives an external bus master read and write access to a bank of 8-bit control registers that live outside the block. Both bus lines are oversampled in the system clock domain, which must run at least eight times faster than the serial clock. Start and stop conditions are recognised, and the block answers only to its own 7-bit device address. Two strap pins set the low address bits, so four such slaves can share one bus.

A write transfer carries a device address byte, then a register pointer byte, then any number of data bytes. Each data byte produces a one-cycle write strobe toward the register bank, and the pointer then advances by one. The pointer never moves past the top register; it stays there. A read transfer returns bytes from the register bank, starting at the current pointer, until the master withholds its acknowledge. The bank supplies read data combinationally for the address the block presents. The block drives the data line only by pulling it low through an open-drain style output.

Top module: `twi_regport`

## Requirements
- R1: A falling SDA while SCL is high (start) begins reception of a device address byte from any state. A rising SDA while SCL is high (stop) returns the block to idle. Between them, the first byte received is seven address bits followed by a direction bit, where 1 means read and 0 means write.
- R2: The device address is binary 10011 followed by sel_i[1] and sel_i[0]. On a match the slave acknowledges. On a mismatch it never pulls SDA for the rest of that transfer.
- R3: sda_pull_o only changes while SCL is low. An acknowledge from the slave is a pull held through the whole of the 9th SCL high period of a byte. While the master owns the line, SDA stays released.
- R4: All bytes travel MSB first. In a write, the byte after the address byte loads the register pointer, and each following data byte gives exactly one reg_wr_o pulse carrying the pointer on reg_addr_o and the byte on reg_wdata_o.
- R5: After each written data byte, the pointer increases by one.
- R6: The pointer saturates at 0x1D: extra written bytes land on 0x1D, and extra read bytes repeat register 0x1D.
- R7: A pointer byte greater than 0x1D is not acknowledged, and no data byte in that transfer is acknowledged or written.
- R8: In a read, each byte put on SDA is the register at the pointer, read with one reg_rd_o pulse. The pointer advances when the master acknowledges a byte.
- R9: A master not-acknowledge ends a read: SDA stays released and no further reg_rd_o pulse occurs until a new start.
- R10: A start in the middle of a byte (repeated start) abandons that byte and restarts address reception. A stop in the middle of a byte leaves SDA released and writes nothing.
- R11: During and right after reset, sda_pull_o, reg_wr_o and reg_rd_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sel_i | input | 2 | Strap pins giving the two low device address bits |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr_o | output | 8 | Register pointer presented to the bank |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data for the strobed register |
| reg_rd_o | output | 1 | One-cycle strobe when a register byte is taken for transmission |
| reg_rdata_i | input | 8 | Bank contents at reg_addr_o, combinational |

## Verification
The hardest situations to reach are the ones where the master abandons a transfer part-way: a repeated start or a stop after only a few bits of a byte, and a master not-acknowledge at the end of a read. The bench gets there by building every transfer from single-bit tasks, so it can cut a byte after any bit and insert a start or stop condition. It also runs reads after writes that pushed the pointer to 0x1D, so the saturated pointer is read back over the bus. A behavioural model of the pointer and the register contents predicts every acknowledge and data bit, and the expected pull is compared on every clock while SCL is high.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK,
    ST_WAIT
  } twi_state_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_REG,
    PH_DATA
  } twi_phase_t;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_line
      logic [STAGES:0] sh_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-1:0], din[g]};
      end

      assign lvl[g]  = sh_q[STAGES-1];
      assign rise[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
      assign fall[g] = ~sh_q[STAGES-1] & sh_q[STAGES];
    end
  endgenerate

endmodule

// File: rtl/twi_ptr.sv
module twi_ptr #(
  parameter int          AW      = 8,
  parameter int unsigned REG_MAX = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr_o
);

  localparam logic [AW-1:0] MAX_V = AW'(REG_MAX);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = 1'b0;
    ptr_d  = ptr_q;
    if (load) begin
      ptr_en = 1'b1;
      ptr_d  = load_val;
    end else if (inc && (ptr_q < MAX_V)) begin
      ptr_en = 1'b1;
      ptr_d  = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R6: pointer never exceeds the top register
  a_r6_ptr_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= MAX_V);

  // R6: an increment at the top leaves the pointer in place
  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && ptr_q == MAX_V) |=> ptr_q == MAX_V);

  // R7: only in-range pointer values are ever loaded
  a_r7_load_range: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> load_val <= MAX_V);

endmodule

// File: rtl/twi_regport.sv
module twi_regport
  import twi_pkg::*;
#(
  parameter int          AW          = 8,
  parameter int          SEL_W       = 2,
  parameter int unsigned DEV_BASE    = 19,
  parameter int unsigned REG_MAX     = 29,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             sda_pull_o,
  output logic [AW-1:0]    reg_addr_o,
  output logic             reg_wr_o,
  output logic [7:0]       reg_wdata_o,
  output logic             reg_rd_o,
  input  logic [7:0]       reg_rdata_i
);

  localparam int              BASE_W = 7 - SEL_W;
  localparam logic [BASE_W-1:0] BASE_V = BASE_W'(DEV_BASE);
  localparam logic [AW-1:0]   MAX_V  = AW'(REG_MAX);
  localparam int              CW     = 4;
  localparam logic [CW-1:0]   BITS   = CW'(8);

  // reset: asserted asynchronously, released synchronously
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // line sampling: bit 1 = SCL, bit 0 = SDA
  logic [1:0] ln_lvl, ln_rise, ln_fall;

  twi_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_ni),
    .din   ({scl_i, sda_i}),
    .lvl   (ln_lvl),
    .rise  (ln_rise),
    .fall  (ln_fall)
  );

  logic scl_lvl, scl_rise, scl_fall, sda_lvl, start_c, stop_c;
  assign scl_lvl  = ln_lvl[1];
  assign scl_rise = ln_rise[1];
  assign scl_fall = ln_fall[1];
  assign sda_lvl  = ln_lvl[0];
  assign start_c  = scl_lvl & ln_fall[0];
  assign stop_c   = scl_lvl & ln_rise[0];

  // state
  twi_state_t    st_q, st_d;
  twi_phase_t    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    sh_q, sh_d, tx_q, tx_d, wdata_q, wdata_d;
  logic          pull_q, pull_d, dir_q, dir_d, ack_q, ack_d;
  logic          mack_q, mack_d, wr_q, wr_d, rd_q, rd_d;
  logic          ptr_load, mack_inc, load_tx;
  logic          byte_full, reg_ok;
  logic [6:0]    dev_id;

  assign dev_id    = {BASE_V, sel_i};
  assign byte_full = (cnt_q == BITS);
  assign reg_ok    = (AW'(sh_q) <= MAX_V);

  twi_ptr #(.AW(AW), .REG_MAX(REG_MAX)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (ptr_load),
    .load_val (AW'(sh_q)),
    .inc      (wr_q | mack_inc),
    .ptr_o    (reg_addr_o)
  );

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    tx_d     = tx_q;
    pull_d   = pull_q;
    dir_d    = dir_q;
    ack_d    = ack_q;
    mack_d   = mack_q;
    wdata_d  = wdata_q;
    wr_d     = 1'b0;
    rd_d     = 1'b0;
    ptr_load = 1'b0;
    mack_inc = 1'b0;
    load_tx  = 1'b0;
    if (start_c) begin
      st_d   = ST_RECV;
      ph_d   = PH_DEV;
      cnt_d  = '0;
      pull_d = 1'b0;
    end else if (stop_c) begin
      st_d   = ST_IDLE;
      pull_d = 1'b0;
    end else begin
      case (st_q)
        ST_RECV: begin
          if (scl_rise && !byte_full) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && byte_full) begin
            cnt_d = '0;
            st_d  = ST_ACK;
            case (ph_q)
              PH_DEV: begin
                ack_d = (sh_q[7:1] == dev_id);
                dir_d = sh_q[0];
              end
              PH_REG: begin
                ack_d    = reg_ok;
                ptr_load = reg_ok;
              end
              default: begin
                ack_d   = 1'b1;
                wr_d    = 1'b1;
                wdata_d = sh_q;
              end
            endcase
            pull_d = ack_d;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            if (!ack_q)                        st_d    = ST_WAIT;
            else if (ph_q == PH_DEV && dir_q)  load_tx = 1'b1;
            else begin
              st_d = ST_RECV;
              ph_d = (ph_q == PH_DEV) ? PH_REG : PH_DATA;
            end
          end
        end
        ST_SEND: begin
          if (scl_fall) begin
            if (cnt_q == CW'(7)) begin
              pull_d = 1'b0;
              cnt_d  = '0;
              st_d   = ST_MACK;
            end else begin
              tx_d   = {tx_q[6:0], 1'b0};
              pull_d = ~tx_q[6];
              cnt_d  = cnt_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d   = ~sda_lvl;
            mack_inc = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) load_tx = 1'b1;
            else        st_d    = ST_WAIT;
          end
        end
        default: ;
      endcase
      if (load_tx) begin
        st_d   = ST_SEND;
        tx_d   = reg_rdata_i;
        pull_d = ~reg_rdata_i[7];
        rd_d   = 1'b1;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_DEV;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      pull_q  <= 1'b0;
      dir_q   <= 1'b0;
      ack_q   <= 1'b0;
      mack_q  <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      wdata_q <= wdata_d;
      pull_q  <= pull_d;
      dir_q   <= dir_d;
      ack_q   <= ack_d;
      mack_q  <= mack_d;
      wr_q    <= wr_d;
      rd_q    <= rd_d;
    end
  end

  assign sda_pull_o  = pull_q;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_rd_o    = rd_q;

  // R3: the pull only moves after SCL was seen low (bus conditions excepted)
  a_r3_pull_on_low: assert property (@(posedge clk) disable iff (!rst_ni)
    (!$stable(sda_pull_o) && !$past(start_c || stop_c)) |-> !$past(scl_lvl));

  // R10: a stop leaves the slave idle and released
  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    stop_c |=> (!sda_pull_o && st_q == ST_IDLE));

  // R4: write and read strobes never coincide
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_ni)
    !(reg_wr_o && reg_rd_o));

  // R5: a write advances the pointer, saturating at the top
  a_r5_post_inc: assert property (@(posedge clk) disable iff (!rst_ni)
    reg_wr_o |=> (reg_addr_o == $past(reg_addr_o) + 1'b1) ||
                 ($past(reg_addr_o) == MAX_V && reg_addr_o == MAX_V));

  // R9: a master not-acknowledge ends the read with SDA released
  a_r9_nack_ends: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_MACK && scl_fall && !mack_q && !start_c && !stop_c)
      |=> (st_q == ST_WAIT && !sda_pull_o));

  // R7: an out-of-range pointer byte is answered with a released line
  a_r7_reg_nack: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_RECV && ph_q == PH_REG && scl_fall && byte_full && !reg_ok &&
     !start_c && !stop_c) |=> (!sda_pull_o && st_q == ST_ACK));

  // R2: no pull is ever issued once the slave is waiting for a new start
  a_r2_wait_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> !sda_pull_o);

endmodule

// File: tb/twi_regport_tb.sv
module twi_regport_tb;

  localparam int Q    = 8;
  localparam int MAXA = 29;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] sel   = 2'b01;
  logic       sda_pull, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire        sda_line = sda_m & ~sda_pull;

  logic [7:0] bank [0:31];
  assign reg_rdata = bank[reg_addr[4:0]];

  twi_regport u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .sel_i       (sel),
    .sda_pull_o  (sda_pull),
    .reg_addr_o  (reg_addr),
    .reg_wr_o    (reg_wr),
    .reg_wdata_o (reg_wdata),
    .reg_rd_o    (reg_rd),
    .reg_rdata_i (reg_rdata)
  );

  int tests = 0;
  int fails = 0;
  int rd_cnt = 0;
  int m_ptr = 0;
  int ref_bank [32];
  int exp_wr_q [$];
  bit exp_pull = 1'b0;
  bit finished = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // register bank behind the port
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) bank[i] <= 8'(i * 7 + 3);
    end else if (reg_wr) begin
      bank[reg_addr[4:0]] <= reg_wdata;
    end
  end

  // per-clock comparison against the model
  always @(posedge clk) begin
    int e;
    #2;
    if (rst_n) begin
      if (scl_m) check("R3 SDA pull while SCL high", int'(sda_pull), int'(exp_pull));
      if (reg_wr) begin
        if (exp_wr_q.size() == 0) check("R7 unexpected write strobe", 1, 0);
        else begin
          e = exp_wr_q.pop_front();
          check("R4 write address/data", int'({reg_addr, reg_wdata}), e);
        end
      end
      if (reg_rd) rd_cnt++;
    end
  end

  function automatic int sat_inc(input int p);
    return (p < MAXA) ? p + 1 : p;
  endfunction

  function automatic logic [7:0] dev(input logic [1:0] s, input logic rw);
    return {5'b10011, s, rw};
  endfunction

  task automatic bit_out(input logic b);
    tick(2); sda_m = b; exp_pull = 1'b0;
    tick(Q); scl_m = 1'b1;
    tick(Q); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    logic got;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    tick(2); sda_m = 1'b1; exp_pull = exp_ack;
    tick(Q); scl_m = 1'b1;
    tick(Q / 2); got = ~sda_line;
    tick(Q / 2); scl_m = 1'b0;
    check(tag, int'(got), int'(exp_ack));
  endtask

  task automatic read_byte(input bit mack, input string tag);
    logic [7:0] got;
    logic [7:0] expb;
    expb = 8'(ref_bank[m_ptr]);
    for (int i = 7; i >= 0; i--) begin
      tick(2); sda_m = 1'b1; exp_pull = ~expb[i];
      tick(Q); scl_m = 1'b1;
      tick(Q / 2); got[i] = sda_line;
      tick(Q / 2); scl_m = 1'b0;
    end
    tick(2); exp_pull = 1'b0; sda_m = ~mack;
    tick(Q); scl_m = 1'b1;
    tick(Q); scl_m = 1'b0;
    if (mack) m_ptr = sat_inc(m_ptr);
    check(tag, int'(got), int'(expb));
  endtask

  task automatic do_start();
    tick(2); sda_m = 1'b1; exp_pull = 1'b0;
    tick(Q); scl_m = 1'b1;
    tick(Q); sda_m = 1'b0;
    tick(Q); scl_m = 1'b0;
  endtask

  task automatic do_stop();
    tick(2); sda_m = 1'b0; exp_pull = 1'b0;
    tick(Q); scl_m = 1'b1;
    tick(Q); sda_m = 1'b1;
    tick(Q);
  endtask

  task automatic send_base(input int b);
    bit ok;
    ok = (b <= MAXA);
    send_byte(8'(b), ok, "R7 pointer byte acknowledge");
    if (ok) m_ptr = b;
  endtask

  task automatic send_data(input logic [7:0] d);
    exp_wr_q.push_back(m_ptr * 256 + int'(d));
    ref_bank[m_ptr] = int'(d);
    m_ptr = sat_inc(m_ptr);
    send_byte(d, 1'b1, "R5 data byte acknowledge");
  endtask

  initial begin
    int rd0;
    for (int i = 0; i < 32; i++) ref_bank[i] = (i * 7 + 3) & 8'hFF;
    tick(5);
    check("R11 pull low in reset", int'(sda_pull), 0);
    check("R11 write strobe low in reset", int'(reg_wr), 0);
    rst_n = 1'b1;
    tick(5);
    check("R11 pull low after reset", int'(sda_pull), 0);
    check("R11 read strobe low after reset", int'(reg_rd), 0);

    // R2: wrong device address is ignored
    do_start();
    send_byte(dev(2'b00, 1'b0), 1'b0, "R2 mismatched address");
    do_stop();

    // R1 R4 R5: plain write of two bytes
    do_start();
    send_byte(dev(2'b01, 1'b0), 1'b1, "R1 matched address after start");
    send_base(3);
    send_data(8'hA5);
    send_data(8'h3C);
    do_stop();
    check("R5 both writes seen", exp_wr_q.size(), 0);

    // R6: write past the top register
    do_start();
    send_byte(dev(2'b01, 1'b0), 1'b1, "R1 address ack");
    send_base(28);
    send_data(8'h11);
    send_data(8'h22);
    send_data(8'h33);
    do_stop();
    check("R6 saturated writes seen", exp_wr_q.size(), 0);

    // R7: out-of-range pointer byte
    do_start();
    send_byte(dev(2'b01, 1'b0), 1'b1, "R1 address ack");
    send_base(30);
    send_byte(8'h77, 1'b0, "R7 data after rejected pointer");
    do_stop();
    check("R7 no write after rejected pointer", exp_wr_q.size(), 0);

    // R8 R9 R10: pointer set, repeated start, read three bytes
    do_start();
    send_byte(dev(2'b01, 1'b0), 1'b1, "R1 address ack");
    send_base(3);
    do_start();
    send_byte(dev(2'b01, 1'b1), 1'b1, "R10 read address after repeated start");
    rd0 = rd_cnt;
    read_byte(1'b1, "R8 first read byte");
    read_byte(1'b1, "R8 second read byte");
    read_byte(1'b0, "R8 third read byte");
    tick(3 * Q);
    check("R9 released after master nack", int'(sda_pull), 0);
    check("R9 read strobe count", rd_cnt - rd0, 3);
    do_stop();

    // R6: reading at the top register repeats it
    do_start();
    send_byte(dev(2'b01, 1'b0), 1'b1, "R1 address ack");
    send_base(29);
    do_start();
    send_byte(dev(2'b01, 1'b1), 1'b1, "R8 read address ack");
    read_byte(1'b1, "R6 top register read");
    read_byte(1'b0, "R6 top register read again");
    do_stop();

    // R10: stop in the middle of the address byte
    do_start();
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b0); bit_out(1'b1);
    do_stop();
    check("R10 released after stop mid-byte", int'(sda_pull), 0);

    // R10: repeated start in the middle of a data byte
    do_start();
    send_byte(dev(2'b01, 1'b0), 1'b1, "R1 address ack");
    send_base(7);
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
    do_start();
    send_byte(dev(2'b01, 1'b0), 1'b1, "R10 address after mid-byte start");
    send_base(8);
    send_data(8'h5E);
    do_stop();
    do_start();
    send_byte(dev(2'b01, 1'b0), 1'b1, "R1 address ack");
    send_base(7);
    do_start();
    send_byte(dev(2'b01, 1'b1), 1'b1, "R8 read address ack");
    read_byte(1'b1, "R10 abandoned byte left register untouched");
    read_byte(1'b0, "R4 write after restart landed");
    do_stop();

    // R2: strap pins move the device address
    sel = 2'b10;
    tick(4);
    do_start();
    send_byte(dev(2'b01, 1'b0), 1'b0, "R2 old address after strap change");
    do_stop();
    do_start();
    send_byte(dev(2'b10, 1'b0), 1'b1, "R2 new strap address");
    send_base(0);
    send_data(8'h81);
    do_stop();
    tick(10);
    check("R4 every expected write seen", exp_wr_q.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule